// File: doc/BRIEF.md
# Four-Word Burst Address Sequencer

This block produces the address for every word of a short burst from one base address. A load cycle captures the external address as the base. Each later advance cycle steps an internal counter. The current address is then formed from the base and that counter. Only the low offset bits (two bits for a four-word burst) move during a burst. The upper bits keep the value of the loaded base.

A static order pin picks one of two sequences within the aligned group. The linear sequence counts upward from the base offset and wraps inside the group. The interleaved sequence XORs the base offset with the step count. The counter wraps after the last word, so further advances repeat the same group rather than moving into the next one.

An active-low clock enable freezes every register when high. A start qualifier marks whether a load begins a real access. A load that is not a valid start leaves the sequencer idle, and advances then produce no new access.

Top module: `burst_addr_seq`

## Requirements
- R1: On an enabled cycle (`cke_n`=0) with `adv_ld`=0, the next cycle shows `addr_out` equal to the sampled `addr_in`, and `burst_live` equal to the sampled `start_ok`.
- R2: With `order_sel`=0 (linear), the k-th enabled advance after a live load gives low two bits equal to (base low bits + k) mod 4, for example 2, 3, 0, 1.
- R3: With `order_sel`=1 (interleaved), the k-th enabled advance after a live load gives low two bits equal to base low bits XOR (k mod 4), for example 1, 0, 3, 2.
- R4: During advances, `addr_out` bits above bit 1 keep the loaded base value.
- R5: The fourth advance after a load returns `addr_out` to the loaded base address, and later advances repeat the same four-address cycle.
- R6: While `cke_n`=1, `addr_out` and `burst_live` hold their values whatever `adv_ld`, `start_ok` and `addr_in` do.
- R7: After a load with `start_ok`=0, `burst_live` is 0, and advance cycles leave `addr_out` and `burst_live` unchanged until the next load.
- R8: While `rst_n` is low and right after it, `addr_out` is 0 and `burst_live` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high freezes all state |
| adv_ld | input | 1 | 1 = advance burst counter, 0 = load new base |
| start_ok | input | 1 | Qualifies a load as a valid access start |
| order_sel | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W (18) | External address captured on a load |
| addr_out | output | ADDR_W (18) | Address of the current burst word |
| burst_live | output | 1 | Current address belongs to an active burst |

## Verification
The bound checker watches, on every cycle, the load capture, the freeze under a high clock enable, the fixed upper bits, the unit step of the linear order, and the idle behaviour after a load that is not a valid start. The interleaved sequence, the return to the base after the fourth word, and the full sequences from each of the four starting offsets in both orders are shown only by the bench's scenarios. Those scenarios compare the design against a separate model, with stalls mixed into the bursts.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  localparam int OFS_W_MAX = 8;

  // Linear offset: base plus step, wrapped to the group by the caller's slice.
  function automatic logic [OFS_W_MAX-1:0] ofs_linear(
      input logic [OFS_W_MAX-1:0] base_ofs,
      input logic [OFS_W_MAX-1:0] step);
    return base_ofs + step;
  endfunction

  // Interleaved offset: base XOR step, never leaves the aligned group.
  function automatic logic [OFS_W_MAX-1:0] ofs_xor(
      input logic [OFS_W_MAX-1:0] base_ofs,
      input logic [OFS_W_MAX-1:0] step);
    return base_ofs ^ step;
  endfunction

  function automatic logic [OFS_W_MAX-1:0] ofs_pick(
      input burst_order_e ord,
      input logic [OFS_W_MAX-1:0] base_ofs,
      input logic [OFS_W_MAX-1:0] step);
    return (ord == ORD_XOR) ? ofs_xor(base_ofs, step)
                            : ofs_linear(base_ofs, step);
  endfunction

endpackage

// File: rtl/burst_step_ctr.sv
`timescale 1ns/1ps
module burst_step_ctr #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [OFS_W-1:0] step_o
);

  logic [OFS_W-1:0] step_q;

  // Natural wrap of an OFS_W-bit counter gives the group wrap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_q <= '0;
    else if (clr)    step_q <= '0;
    else if (inc)    step_q <= step_q + 1'b1;
  end

  assign step_o = step_q;

endmodule

// File: rtl/burst_base_reg.sv
`timescale 1ns/1ps
module burst_base_reg #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              start_ok,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_o,
  output logic              live_o
);

  logic [ADDR_W-1:0] base_q;
  logic              live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      live_q <= 1'b0;
    end else if (load) begin
      base_q <= addr_in;
      live_q <= start_ok;
    end
  end

  assign base_o = base_q;
  assign live_o = live_q;

endmodule

// File: rtl/burst_addr_map.sv
`timescale 1ns/1ps
module burst_addr_map
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int OFS_W  = 2
) (
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFS_W-1:0]  step_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [OFS_W_MAX-1:0] base_wide;
  logic [OFS_W_MAX-1:0] step_wide;
  logic [OFS_W_MAX-1:0] ofs_wide;
  burst_order_e         ord;

  assign ord       = burst_order_e'(order_sel);
  assign base_wide = OFS_W_MAX'(base_i[OFS_W-1:0]);
  assign step_wide = OFS_W_MAX'(step_i);
  assign ofs_wide  = ofs_pick(ord, base_wide, step_wide);

  generate
    if (ADDR_W > OFS_W) begin : g_hi
      assign addr_o = {base_i[ADDR_W-1:OFS_W], ofs_wide[OFS_W-1:0]};
    end else begin : g_lo_only
      assign addr_o = ofs_wide[OFS_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq #(
  parameter int ADDR_W    = 18,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              adv_ld,
  input  logic              start_ok,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_live
);

  localparam int OFS_W = $clog2(BURST_LEN);

  logic              ld_fire;
  logic              adv_fire;
  logic [ADDR_W-1:0] base_addr;
  logic [OFS_W-1:0]  step_cnt;

  // Named events: a load on an enabled cycle, an advance inside a live burst.
  assign ld_fire  = !cke_n && !adv_ld;
  assign adv_fire = !cke_n &&  adv_ld && burst_live;

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld_fire),
    .start_ok (start_ok),
    .addr_in  (addr_in),
    .base_o   (base_addr),
    .live_o   (burst_live)
  );

  burst_step_ctr #(.OFS_W(OFS_W)) u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ld_fire),
    .inc    (adv_fire),
    .step_o (step_cnt)
  );

  burst_addr_map #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_map (
    .order_sel (order_sel),
    .base_i    (base_addr),
    .step_i    (step_cnt),
    .addr_o    (addr_out)
  );

endmodule

// File: rtl/burst_addr_seq_chk.sv
`timescale 1ns/1ps
module burst_addr_seq_chk #(
  parameter int ADDR_W = 18,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke_n,
  input logic              adv_ld,
  input logic              start_ok,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              burst_live,
  input logic              ld_fire,
  input logic              adv_fire
);

  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

  // R1: load captures address and qualifier
  p_load_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |=> (addr_out == $past(addr_in)) && (burst_live == $past(start_ok)));

  // R6: frozen while clock enable is high
  p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> (order_sel != $past(order_sel)) ||
              ($stable(addr_out) && $stable(burst_live)));

  // R4: upper address bits fixed across an advance
  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv_fire |=> addr_out[ADDR_W-1:OFS_W] == $past(addr_out[ADDR_W-1:OFS_W]));

  // R2: linear order steps the offset by one, wrapping
  p_linear_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && !order_sel) |=> (order_sel != $past(order_sel)) ||
      (addr_out[OFS_W-1:0] == $past(addr_out[OFS_W-1:0]) + ONE));

  // R7: no new access from advances while idle
  p_idle_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv_ld && !burst_live) |=> (order_sel != $past(order_sel)) ||
      ($stable(addr_out) && !burst_live));

  // R8: reset state
  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_state_r8: assert (addr_out == '0 && !burst_live);
    end
  end

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke_n      (cke_n),
  .adv_ld     (adv_ld),
  .start_ok   (start_ok),
  .order_sel  (order_sel),
  .addr_in    (addr_in),
  .addr_out   (addr_out),
  .burst_live (burst_live),
  .ld_fire    (ld_fire),
  .adv_fire   (adv_fire)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke_n = 1'b0;
  logic          adv_ld = 1'b1;
  logic          start_ok = 1'b0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          burst_live;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // Bench model state
  logic [AW-1:0] m_base = '0;
  int            m_step = 0;
  bit            m_live = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv_ld(adv_ld),
    .start_ok(start_ok), .order_sel(order_sel), .addr_in(addr_in),
    .addr_out(addr_out), .burst_live(burst_live)
  );

  // Expected address, restated per bit rather than by formula
  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int s,
                                             input bit ilv);
    logic [1:0] lo;
    logic [1:0] sv;
    sv = 2'(s % 4);
    if (ilv) lo = {b[1] ^ sv[1], b[0] ^ sv[0]};
    else     lo = 2'((int'(b[1:0]) + s) % 4);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] act_a,
                       input logic [AW-1:0] exp_a, input bit act_l, input bit exp_l);
    n_chk++;
    if (act_a !== exp_a || act_l !== exp_l) begin
      n_err++;
      $display("FAIL %s: addr=%h live=%0b expected addr=%h live=%0b",
               tag, act_a, act_l, exp_a, exp_l);
    end
  endtask

  // One cycle: drive at negedge, update model, check at the following negedge.
  task automatic cyc(input bit adv, input bit stall, input bit ok,
                     input logic [AW-1:0] a, input string tag);
    adv_ld = adv; cke_n = stall; start_ok = ok; addr_in = a;
    if (!stall) begin
      if (!adv) begin m_base = a; m_step = 0; m_live = ok; end
      else if (m_live) m_step = (m_step + 1) % 4;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, addr_out, exp_addr(m_base, m_step, order_sel), burst_live, m_live);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R8: reset state while held and after release
    check("R8", addr_out, '0, burst_live, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", addr_out, '0, burst_live, 1'b0);

    // Directed: both orders, all four offsets, a stall mid-burst, wrap past four
    for (int m = 0; m < 2; m++) begin
      for (int o = 0; o < 4; o++) begin
        logic [AW-1:0] a;
        a = {16'($urandom), 2'(o)};
        order_sel = m[0];
        cyc(1'b0, 1'b0, 1'b1, a, "R1");
        for (int k = 1; k <= 6; k++) begin
          cyc(1'b1, 1'b0, $urandom_range(0, 1) != 0, $urandom, (m == 0) ? "R2" : "R3");
          n_chk++;
          if (addr_out[AW-1:2] !== a[AW-1:2]) begin
            n_err++;
            $display("FAIL R4: upper=%h expected=%h", addr_out[AW-1:2], a[AW-1:2]);
          end
          if (k == 4) begin
            n_chk++;
            if (addr_out !== a) begin
              n_err++;
              $display("FAIL R5: addr=%h expected=%h", addr_out, a);
            end
          end
          if (k == 2) begin
            cyc(1'b1, 1'b1, 1'b1, $urandom, "R6");
            cyc(1'b0, 1'b1, 1'b0, $urandom, "R6");
          end
        end
      end
    end

    // R7: load that is not a valid start, then advances
    order_sel = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 18'h2_3456, "R7");
    repeat (5) cyc(1'b1, 1'b0, 1'b1, $urandom, "R7");
    order_sel = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, 18'h1_0001, "R1");
    cyc(1'b1, 1'b0, 1'b0, '0, "R3");
    cyc(1'b0, 1'b0, 1'b0, 18'h0_00ff, "R7");
    cyc(1'b1, 1'b0, 1'b1, '0, "R7");

    // Constrained random: order changes only together with a load
    for (int i = 0; i < 800; i++) begin
      bit adv, stall;
      adv   = ($urandom_range(0, 9) < 7);
      stall = ($urandom_range(0, 9) < 2);
      if (!adv && !stall) order_sel = $urandom_range(0, 1) != 0;
      cyc(adv, stall, $urandom_range(0, 9) < 8, $urandom,
          stall ? "R6" : (!adv ? "R1" : (order_sel ? "R3" : "R2")));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule